// File: doc/BRIEF.md
# Receive DMA Pointer Engine with Queued Second Buffer

This block writes incoming converted samples straight into memory, so that no processor has to copy them. It holds two address/count pairs. The active pair says where the next sample lands and how many samples are still wanted. The queued pair is the buffer that software has already prepared. Each sample that is accepted is written at the active address. The address then moves on by one halfword and the count drops by one.

When the active count is used up, the queued pair moves into the active slot at the same clock edge, with no idle cycle. This double buffering lets software refill one buffer while the other one fills. Two sticky flags report what happened. One says a buffer has completed. The other says both buffers are exhausted, and at that point the engine stalls. Each flag has a mask bit, and the masked flags are ORed into one interrupt line.

The sample side and the memory side are both plain valid/ready links. A sample passes through in the same cycle that the memory accepts it, so the block adds no storage of its own.

Top module: `rx_dma_engine`

## Requirements
- R1: After reset, both addresses and both counts are 0, the engine is disabled, both flags and both mask bits are 0, and `irq_o` is 0.
- R2: A cycle with `reg_wr_en` high loads `reg_wr_data` into one register, chosen by `reg_wr_sel`: 0 = active address, 1 = active count, 2 = queued address, 3 = queued count. Counts take the low 16 bits. The new value is visible after the next edge. In that cycle `mem_valid` and `smp_ready` are held low and no sample moves.
- R3: A control write with bit 1 set disables the engine. Otherwise, a control write with bit 0 set enables it. A write with both bits set leaves the engine disabled. `rx_enabled_o` shows the state.
- R4: While the engine is enabled, the active count is nonzero and no register write is taking place, the following hold: `mem_valid` follows `smp_valid`, `smp_ready` follows `mem_ready`, `mem_addr` is the active address and `mem_data` is `smp_data`. Otherwise `mem_valid` and `smp_ready` are 0.
- R5: Each accepted sample (`mem_valid` and `mem_ready` both high) adds 2 to the active address, which wraps modulo 2^32, and subtracts 1 from the active count.
- R6: A sample that takes the active count to 0 while the queued count is nonzero copies the queued pair into the active pair at that same edge and clears the queued count to 0.
- R7: A sample that takes the active count to 0 sets the end-of-buffer flag `end_buf_o`, whether or not a reload follows. Writing a nonzero active count clears it. Writing a zero active count leaves it set.
- R8: A sample that takes the active count to 0 while the queued count is 0 sets `buf_full_o`. No further sample is accepted until a count is written. Writing a nonzero queued count clears `buf_full_o`. Writing a zero queued count leaves it set.
- R9: When the active count is 0 and the queued count is nonzero outside a register write, the queued pair is copied into the active pair at the next edge, and the queued count becomes 0.
- R10: Mask bit 0 belongs to end-of-buffer and mask bit 1 to buffer-full. An `irq_en_wr` pulse sets the mask bits selected by `irq_sel`, and an `irq_dis_wr` pulse clears them. When both pulses arrive together, the disable wins. `irq_o` is the OR of each flag ANDed with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (see R2) |
| reg_wr_data | input | 32 | Register write value |
| xfer_ctl_wr | input | 1 | Control write strobe |
| xfer_ctl_data | input | 2 | Bit 0 enable, bit 1 disable |
| irq_en_wr | input | 1 | Mask set strobe |
| irq_dis_wr | input | 1 | Mask clear strobe |
| irq_sel | input | 2 | Mask bits addressed by the strobes |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken |
| smp_data | input | 16 | Sample value |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Byte address of the write |
| mem_data | output | 16 | Halfword written |
| cur_ptr_o | output | 32 | Active address |
| cur_cnt_o | output | 16 | Active count |
| nxt_ptr_o | output | 32 | Queued address |
| nxt_cnt_o | output | 16 | Queued count |
| rx_enabled_o | output | 1 | Engine enabled |
| end_buf_o | output | 1 | End-of-buffer flag |
| buf_full_o | output | 1 | Both buffers exhausted |
| irq_mask_o | output | 2 | Mask bits |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, 16-bit counts, 16-bit samples and a 2-byte step. The 32-bit address lets the bench start a buffer at the top halfword of the address space and watch it wrap to zero. Counts of a few samples are enough to reach a reload, the stall when both buffers are empty and the restart from idle within a few dozen cycles. A behavioural model compares every output on every cycle while the memory side throttles and register writes collide with pending samples.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef enum logic [1:0] {
    SEL_CUR_PTR = 2'd0,
    SEL_CUR_CNT = 2'd1,
    SEL_NXT_PTR = 2'd2,
    SEL_NXT_CNT = 2'd3
  } dma_sel_e;

  localparam int FLG_END  = 0;
  localparam int FLG_FULL = 1;
  localparam int NUM_FLG  = 2;
endpackage

// File: rtl/rx_dma_gate.sv
module rx_dma_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_data,
  output logic       enabled
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_q <= 1'b0;
    else if (ctl_wr && ctl_data[1]) en_q <= 1'b0;
    else if (ctl_wr && ctl_data[0]) en_q <= 1'b1;
  end

  assign enabled = en_q;

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[1] |=> !enabled); // R3
  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data == 2'b01 |=> enabled); // R3
endmodule

// File: rtl/rx_dma_ptrs.sv
module rx_dma_ptrs
  import rx_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  dma_sel_e          reg_wr_sel,
  input  logic [ADDR_W-1:0] reg_wr_data,
  input  logic              fire,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [ADDR_W-1:0] nxt_ptr,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              drained,
  output logic              starved,
  output logic              reload
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  localparam logic [CNT_W-1:0]  ONE_V  = CNT_W'(1);

  function automatic logic [ADDR_W-1:0] adv_ptr(input logic [ADDR_W-1:0] p);
    return p + STEP_V;
  endfunction

  function automatic logic [CNT_W-1:0] dec_cnt(input logic [CNT_W-1:0] c);
    return c - ONE_V;
  endfunction

  logic [ADDR_W-1:0] ptr_after;
  logic [CNT_W-1:0]  cnt_after;

  always_comb begin
    ptr_after = fire ? adv_ptr(cur_ptr) : cur_ptr;
    cnt_after = fire ? dec_cnt(cur_cnt) : cur_cnt;
  end

  assign drained = fire && (cur_cnt == ONE_V);
  assign starved = drained && (nxt_cnt == '0);
  assign reload  = !reg_wr_en && (cnt_after == '0) && (nxt_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr <= '0;
      cur_cnt <= '0;
      nxt_ptr <= '0;
      nxt_cnt <= '0;
    end else if (reg_wr_en) begin
      case (reg_wr_sel)
        SEL_CUR_PTR: cur_ptr <= reg_wr_data;
        SEL_CUR_CNT: cur_cnt <= reg_wr_data[CNT_W-1:0];
        SEL_NXT_PTR: nxt_ptr <= reg_wr_data;
        SEL_NXT_CNT: nxt_cnt <= reg_wr_data[CNT_W-1:0];
        default: ;
      endcase
    end else if (reload) begin
      cur_ptr <= nxt_ptr;
      cur_cnt <= nxt_cnt;
      nxt_cnt <= '0;
    end else begin
      cur_ptr <= ptr_after;
      cur_cnt <= cnt_after;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cur_cnt > ONE_V |=> cur_ptr == $past(cur_ptr) + STEP_V && cur_cnt == $past(cur_cnt) - ONE_V); // R5
  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cur_cnt == ONE_V && nxt_cnt != '0 |=> cur_ptr == $past(nxt_ptr) && cur_cnt == $past(nxt_cnt) && nxt_cnt == '0); // R6
  AST_IDLE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en && !fire && cur_cnt == '0 && nxt_cnt != '0 |=> cur_cnt == $past(nxt_cnt) && nxt_cnt == '0); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_wr_sel == SEL_CUR_PTR |=> cur_ptr == $past(reg_wr_data)); // R2
endmodule

// File: rtl/rx_dma_status.sv
module rx_dma_status
  import rx_dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FLG-1:0] flag_set,
  input  logic [NUM_FLG-1:0] flag_clr,
  input  logic               irq_en_wr,
  input  logic               irq_dis_wr,
  input  logic [NUM_FLG-1:0] irq_sel,
  output logic [NUM_FLG-1:0] flag_q,
  output logic [NUM_FLG-1:0] mask_q,
  output logic               irq
);
  for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
    logic flag_r;
    logic mask_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_r <= 1'b0;
      else if (flag_set[i]) flag_r <= 1'b1;
      else if (flag_clr[i]) flag_r <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mask_r <= 1'b0;
      else if (irq_dis_wr && irq_sel[i]) mask_r <= 1'b0;
      else if (irq_en_wr && irq_sel[i])  mask_r <= 1'b1;
    end

    assign flag_q[i] = flag_r;
    assign mask_q[i] = mask_r;

    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      irq_dis_wr && irq_sel[i] |=> !mask_q[i]); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] && !flag_clr[i] |=> flag_q[i]); // R7
  end

  assign irq = |(flag_q & mask_q);
endmodule

// File: rtl/rx_dma_engine.sv
module rx_dma_engine
  import rx_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [ADDR_W-1:0] reg_wr_data,
  input  logic              xfer_ctl_wr,
  input  logic [1:0]        xfer_ctl_data,
  input  logic              irq_en_wr,
  input  logic              irq_dis_wr,
  input  logic [1:0]        irq_sel,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic [ADDR_W-1:0] nxt_ptr_o,
  output logic [CNT_W-1:0]  nxt_cnt_o,
  output logic              rx_enabled_o,
  output logic              end_buf_o,
  output logic              buf_full_o,
  output logic [1:0]        irq_mask_o,
  output logic              irq_o
);
  dma_sel_e           wr_sel;
  logic               enabled;
  logic               active;
  logic               fire;
  logic               drained;
  logic               starved;
  logic               reload;
  logic               wr_cur_nz;
  logic               wr_nxt_nz;
  logic [NUM_FLG-1:0] flag_set;
  logic [NUM_FLG-1:0] flag_clr;
  logic [NUM_FLG-1:0] flag_q;

  assign wr_sel = dma_sel_e'(reg_wr_sel);

  rx_dma_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (xfer_ctl_wr),
    .ctl_data (xfer_ctl_data),
    .enabled  (enabled)
  );

  assign active    = enabled && (cur_cnt_o != '0) && !reg_wr_en;
  assign mem_valid = smp_valid && active;
  assign smp_ready = mem_ready && active;
  assign mem_addr  = cur_ptr_o;
  assign mem_data  = smp_data;
  assign fire      = mem_valid && mem_ready;

  rx_dma_ptrs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .STEP   (STEP)
  ) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (wr_sel),
    .reg_wr_data (reg_wr_data),
    .fire        (fire),
    .cur_ptr     (cur_ptr_o),
    .cur_cnt     (cur_cnt_o),
    .nxt_ptr     (nxt_ptr_o),
    .nxt_cnt     (nxt_cnt_o),
    .drained     (drained),
    .starved     (starved),
    .reload      (reload)
  );

  assign wr_cur_nz = reg_wr_en && wr_sel == SEL_CUR_CNT && reg_wr_data[CNT_W-1:0] != '0;
  assign wr_nxt_nz = reg_wr_en && wr_sel == SEL_NXT_CNT && reg_wr_data[CNT_W-1:0] != '0;

  always_comb begin
    flag_set           = '0;
    flag_clr           = '0;
    flag_set[FLG_END]  = drained;
    flag_set[FLG_FULL] = starved;
    flag_clr[FLG_END]  = wr_cur_nz;
    flag_clr[FLG_FULL] = wr_nxt_nz;
  end

  rx_dma_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_set   (flag_set),
    .flag_clr   (flag_clr),
    .irq_en_wr  (irq_en_wr),
    .irq_dis_wr (irq_dis_wr),
    .irq_sel    (irq_sel),
    .flag_q     (flag_q),
    .mask_q     (irq_mask_o),
    .irq        (irq_o)
  );

  assign end_buf_o  = flag_q[FLG_END];
  assign buf_full_o = flag_q[FLG_FULL];

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enabled_o |-> !mem_valid && !smp_ready); // R4
  assign rx_enabled_o = enabled;
  AST_FULL_BOTH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full_o) |-> cur_cnt_o == '0 && nxt_cnt_o == '0 && end_buf_o); // R8
  AST_NO_XFER_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> $past(cur_cnt_o) == cur_cnt_o || $past(wr_sel) == SEL_CUR_CNT); // R2
  AST_RELOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> !reg_wr_en && !starved); // R6
endmodule

// File: tb/rx_dma_engine_tb_top.sv
module rx_dma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = 32'd0;
  logic        xfer_ctl_wr = 1'b0;
  logic [1:0]  xfer_ctl_data = 2'd0;
  logic        irq_en_wr = 1'b0;
  logic        irq_dis_wr = 1'b0;
  logic [1:0]  irq_sel = 2'd0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = 16'd0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic [31:0] cur_ptr_o;
  logic [15:0] cur_cnt_o;
  logic [31:0] nxt_ptr_o;
  logic [15:0] nxt_cnt_o;
  logic        rx_enabled_o;
  logic        end_buf_o;
  logic        buf_full_o;
  logic [1:0]  irq_mask_o;
  logic        irq_o;

  always #4 clk = ~clk;

  rx_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .xfer_ctl_wr(xfer_ctl_wr), .xfer_ctl_data(xfer_ctl_data),
    .irq_en_wr(irq_en_wr), .irq_dis_wr(irq_dis_wr), .irq_sel(irq_sel),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .cur_ptr_o(cur_ptr_o), .cur_cnt_o(cur_cnt_o), .nxt_ptr_o(nxt_ptr_o), .nxt_cnt_o(nxt_cnt_o),
    .rx_enabled_o(rx_enabled_o), .end_buf_o(end_buf_o), .buf_full_o(buf_full_o),
    .irq_mask_o(irq_mask_o), .irq_o(irq_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference state
  logic [31:0] m_cp, m_np;
  int          m_cc, m_nc;
  bit          m_en, m_end, m_full;
  bit [1:0]    m_mask;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cp = 0; m_np = 0; m_cc = 0; m_nc = 0;
    m_en = 0; m_end = 0; m_full = 0; m_mask = 0;
  endtask

  task automatic compare_all();
    bit act;
    act = m_en && m_cc != 0 && !reg_wr_en;
    check("R4", "mem_valid", {31'd0, mem_valid}, {31'd0, smp_valid && act});
    check("R4", "smp_ready", {31'd0, smp_ready}, {31'd0, mem_ready && act});
    if (act && smp_valid) begin
      check("R4", "mem_addr", mem_addr, m_cp);
      check("R4", "mem_data", {16'd0, mem_data}, {16'd0, smp_data});
    end
    check("R5", "cur_ptr", cur_ptr_o, m_cp);
    check("R5", "cur_cnt", {16'd0, cur_cnt_o}, m_cc);
    check("R6", "nxt_ptr", nxt_ptr_o, m_np);
    check("R6", "nxt_cnt", {16'd0, nxt_cnt_o}, m_nc);
    check("R3", "enabled", {31'd0, rx_enabled_o}, {31'd0, m_en});
    check("R7", "end_buf", {31'd0, end_buf_o}, {31'd0, m_end});
    check("R8", "buf_full", {31'd0, buf_full_o}, {31'd0, m_full});
    check("R10", "mask", {30'd0, irq_mask_o}, {30'd0, m_mask});
    check("R10", "irq", {31'd0, irq_o}, {31'd0, (m_end && m_mask[0]) || (m_full && m_mask[1])});
  endtask

  task automatic model_step();
    bit fire;
    fire = smp_valid && mem_ready && m_en && m_cc != 0 && !reg_wr_en;
    if (reg_wr_en) begin
      case (reg_wr_sel)
        2'd0: m_cp = reg_wr_data;
        2'd1: begin m_cc = reg_wr_data[15:0]; if (reg_wr_data[15:0] != 0) m_end = 0; end
        2'd2: m_np = reg_wr_data;
        default: begin m_nc = reg_wr_data[15:0]; if (reg_wr_data[15:0] != 0) m_full = 0; end
      endcase
    end else begin
      if (fire) begin
        m_cp = m_cp + 32'd2;
        m_cc = m_cc - 1;
        if (m_cc == 0) begin
          m_end = 1;
          if (m_nc == 0) m_full = 1;
        end
      end
      if (m_cc == 0 && m_nc != 0) begin
        m_cp = m_np; m_cc = m_nc; m_nc = 0;
      end
    end
    if (xfer_ctl_wr) begin
      if (xfer_ctl_data[1]) m_en = 0;
      else if (xfer_ctl_data[0]) m_en = 1;
    end
    for (int k = 0; k < 2; k++) begin
      if (irq_dis_wr && irq_sel[k]) m_mask[k] = 0;
      else if (irq_en_wr && irq_sel[k]) m_mask[k] = 1;
    end
  endtask

  // one cycle: settle, compare, predict, cross the edge
  task automatic tick();
    #1;
    compare_all();
    model_step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = data;
    tick();
    reg_wr_en = 0;
  endtask

  task automatic ctl(input logic [1:0] d);
    xfer_ctl_wr = 1; xfer_ctl_data = d;
    tick();
    xfer_ctl_wr = 0;
  endtask

  task automatic stream(input int n, input bit throttle);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1;
      smp_data  = 16'hA000 + 16'(i * 7);
      mem_ready = throttle ? (i % 3 != 1) : 1'b1;
      tick();
    end
    smp_valid = 0; mem_ready = 0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "reset cur_ptr", cur_ptr_o, 32'd0);
    check("R1", "reset cur_cnt", {16'd0, cur_cnt_o}, 32'd0);
    check("R1", "reset enabled", {31'd0, rx_enabled_o}, 32'd0);
    check("R1", "reset flags", {29'd0, end_buf_o, buf_full_o, irq_o}, 32'd0);
    check("R1", "reset mask", {30'd0, irq_mask_o}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    tick();

    // R2 register loads
    wr_reg(2'd0, 32'h0000_1000);
    wr_reg(2'd1, 32'hFFFF_0003);
    wr_reg(2'd2, 32'h0000_2000);
    wr_reg(2'd3, 32'd2);
    #1;
    check("R2", "cur_cnt low bits", {16'd0, cur_cnt_o}, 32'd3);
    check("R2", "nxt_ptr loaded", nxt_ptr_o, 32'h0000_2000);

    // R4 no traffic while disabled
    stream(3, 0);

    // masks on, then enable
    irq_en_wr = 1; irq_sel = 2'b11; tick(); irq_en_wr = 0;
    ctl(2'b01);

    // R5/R6/R7/R8 stream through both buffers with throttling
    stream(12, 1);
    #1;
    check("R8", "full after both drained", {31'd0, buf_full_o}, 32'd1);
    check("R7", "end after drain", {31'd0, end_buf_o}, 32'd1);
    check("R6", "ptr after reload+drain", cur_ptr_o, 32'h0000_2004);
    stream(3, 0);

    // R8 zero write does not clear, nonzero clears; R9 reload from idle
    wr_reg(2'd3, 32'd0);
    check("R8", "full kept on zero write", {31'd0, buf_full_o}, 32'd1);
    wr_reg(2'd2, 32'h0000_3000);
    wr_reg(2'd3, 32'd4);
    check("R8", "full cleared", {31'd0, buf_full_o}, 32'd0);
    tick();
    check("R9", "idle reload ptr", cur_ptr_o, 32'h0000_3000);
    check("R9", "idle reload cnt", {16'd0, cur_cnt_o}, 32'd4);

    // R2 a register write blocks a pending sample
    smp_valid = 1; mem_ready = 1;
    reg_wr_en = 1; reg_wr_sel = 2'd2; reg_wr_data = 32'h0000_4000;
    #1;
    check("R2", "no transfer during write", {31'd0, mem_valid}, 32'd0);
    tick();
    reg_wr_en = 0;
    stream(2, 0);

    // R7 zero write keeps end flag, nonzero write clears it
    wr_reg(2'd1, 32'd0);
    check("R7", "end kept on zero write", {31'd0, end_buf_o}, 32'd1);
    wr_reg(2'd1, 32'd5);
    check("R7", "end cleared", {31'd0, end_buf_o}, 32'd0);

    // R3 both bits: disabled
    ctl(2'b11);
    check("R3", "both bits disable", {31'd0, rx_enabled_o}, 32'd0);
    stream(2, 0);

    // R5 address wrap
    wr_reg(2'd0, 32'hFFFF_FFFE);
    wr_reg(2'd1, 32'd2);
    ctl(2'b01);
    stream(1, 0);
    check("R5", "address wraps", cur_ptr_o, 32'd0);
    stream(3, 1);

    // R10 disable wins over enable
    irq_en_wr = 1; irq_dis_wr = 1; irq_sel = 2'b01; tick();
    irq_en_wr = 0; irq_dis_wr = 0;
    check("R10", "disable wins", {30'd0, irq_mask_o}, 32'd2);
    irq_dis_wr = 1; irq_sel = 2'b10; tick(); irq_dis_wr = 0;
    check("R10", "irq low with no mask", {31'd0, irq_o}, 32'd0);
    ctl(2'b10);
    repeat (3) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule